// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock for an SD or MMC interface from the host clock. Software programs one 32-bit control word. The word selects a power-of-two divide ratio from 1 to 1024, turns the card clock on or off, and can let the clock stop on its own while the bus has nothing to do. The divided clock is made of whole high and low phases. Each phase lasts half of the ratio's period, counted in host cycles. A new ratio is taken up only where a low phase ends, so reprogramming the divider never emits a shortened pulse.

The ratio encoding is irregular:
- Eight one-hot bits each pick one ratio from 4 to 512.
- A separate bit picks the undivided host clock.
- A separate bit picks 1024. This ratio is present only when a build parameter allows it.
- An empty ratio field means divide by 2.

Software is expected to clear the enable bit, change the ratio, and then enable again. Whenever the enable bit is clear, the output falls cleanly and stays low.

Top module: `sdclk_divider`

## Requirements
- R1: After reset the control word reads as zero and `card_clk` is low.
- R2: A write with `cfg_we` high replaces the whole 32-bit control word on that clock edge, and `cfg_rdata` returns the last value written. Without a write the word holds.
- R3: Setting bit 8 (enable) runs the clock. Setting one bit i of bits 0..7 gives divide by 2^(i+2). An all-zero ratio field (bits 0..7, 10 and 16 clear) gives divide by 2. Every high and every low phase lasts half the ratio, in host cycles.
- R4: With bit 10 set and bits 0..7 and 16 clear, `card_clk` follows the host clock: high in every high half of `clk`, low in every low half.
- R5: If several of bits 0..7 are set, the largest ratio among them is used. Bit 10 is ignored while any of bits 0..7 or bit 16 is set.
- R6: Bit 16 selects divide by 1024 when `ALLOW_DIV1024` is 1. When it is 0, bit 16 selects divide by 512. Bit 16 outranks bits 0..7.
- R7: With bit 8 clear, `card_clk` stays low. A divided high phase already under way finishes at its full length first. Host-rate pulses stop from the next rising host edge.
- R8: With bit 9 set, a high `bus_idle` stops the clock exactly as R7 does, and a low `bus_idle` lets it run again. With bit 9 clear, `bus_idle` has no effect.
- R9: A ratio change made while the clock runs takes effect at the first end of a low phase. Phases already under way, and a low phase that follows a high phase under way, keep the old length.
- R10: After a stop, the first high phase begins only after one full low phase of the programmed ratio, counted from the edge that writes the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| bus_idle | input | 1 | High while the card bus is unused |
| card_clk | output | 1 | Divided card clock |

## Verification
Two functions can fall into the same host cycle: a register write that changes the ratio or clears the enable, and the divider's own end of a high phase. The bench provokes this by waiting for a rising card clock edge and landing the write one cycle later, while that high phase is still running. A scoreboard then judges the outcome from measured phase lengths. It expects the phase under way and the low phase after it at the old length, then the new length, or a high phase at full length followed by a steady low. The same race is provoked between `bus_idle` rising and a high phase, which must complete before the clock parks low.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // control word geometry; bit positions are decoded by software and by the divider
    localparam int CTRL_W       = 32;
    localparam int SEL_LO       = 0;   // first of the one-hot ratio bits
    localparam int SEL_N        = 8;   // one-hot bits for divide by 4 .. 512
    localparam int CLK_EN_BIT   = 8;
    localparam int IDLE_OFF_BIT = 9;
    localparam int BYPASS_BIT   = 10;
    localparam int SLOW_BIT     = 16;

    // ratio expressed as an exponent: divide by 2**exp, exp 0 means undivided
    localparam int EXP_MAX = 10;
    localparam int EXP_W   = $clog2(EXP_MAX + 1);
    localparam int HALF_W  = EXP_MAX;

    typedef logic [EXP_W-1:0]  ratio_exp_t;
    typedef logic [HALF_W-1:0] half_cnt_t;

    typedef struct packed {
        logic             clk_on;
        logic             idle_gate;
        logic             bypass;
        logic             slow;
        logic [SEL_N-1:0] sel;
    } ctrl_fields_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_fields_t f;
        f.clk_on    = w[CLK_EN_BIT];
        f.idle_gate = w[IDLE_OFF_BIT];
        f.bypass    = w[BYPASS_BIT];
        f.slow      = w[SLOW_BIT];
        f.sel       = w[SEL_LO +: SEL_N];
        return f;
    endfunction

    // terminal count of one half period for a given exponent (half length minus one)
    function automatic half_cnt_t half_last(input ratio_exp_t e);
        if (e == '0)
            return '0;
        return (half_cnt_t'(1) << (e - ratio_exp_t'(1))) - half_cnt_t'(1);
    endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_word,
    output ctrl_fields_t      fields
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_word <= '0;
        else if (wr_en)
            ctrl_word <= wr_data;
    end

    assign fields = unpack_ctrl(ctrl_word);

endmodule

// File: rtl/sdclk_ratio_decode.sv
module sdclk_ratio_decode
    import sdclk_pkg::*;
#(
    parameter bit ALLOW_SLOW = 1'b1
) (
    input  ctrl_fields_t fields,
    input  logic         bus_idle,
    output logic         run,
    output ratio_exp_t   want_exp
);

    ratio_exp_t cand [SEL_N];
    ratio_exp_t slow_exp;

    for (genvar i = 0; i < SEL_N; i++) begin : g_sel
        assign cand[i] = ratio_exp_t'(i + 2);
    end

    if (ALLOW_SLOW) begin : g_slow_full
        assign slow_exp = ratio_exp_t'(EXP_MAX);
    end else begin : g_slow_cap
        assign slow_exp = ratio_exp_t'(EXP_MAX - 1);
    end

    // ascending scan: the highest set one-hot bit wins, the slow bit outranks all
    always_comb begin
        want_exp = fields.bypass ? ratio_exp_t'(0) : ratio_exp_t'(1);
        for (int i = 0; i < SEL_N; i++) begin
            if (fields.sel[i])
                want_exp = cand[i];
        end
        if (fields.slow)
            want_exp = slow_exp;
    end

    assign run = fields.clk_on & ~(fields.idle_gate & bus_idle);

endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen
    import sdclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  ratio_exp_t want_exp,
    output ratio_exp_t act_exp,
    output logic       div_q,
    output logic       pass_gate,
    output logic       card_clk
);

    half_cnt_t cnt;
    logic      at_end;
    logic      bypass_mode;

    assign bypass_mode = (act_exp == '0);
    assign at_end      = (cnt == half_last(act_exp));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= 1'b0;
            cnt     <= '0;
            act_exp <= ratio_exp_t'(1);
        end else if (bypass_mode) begin
            // host-rate mode: divided path parked low, leave on stop or ratio change
            div_q <= 1'b0;
            cnt   <= '0;
            if (!run || want_exp != '0)
                act_exp <= want_exp;
        end else if (div_q) begin
            // a high phase always completes at its own length
            if (at_end) begin
                div_q <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (!run) begin
            // parked low: track the programmed ratio, restart with a full low phase
            cnt     <= '0;
            act_exp <= want_exp;
        end else if (at_end) begin
            // end of a low phase: the only place the ratio is adopted
            cnt     <= '0;
            act_exp <= want_exp;
            div_q   <= (want_exp != '0);
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // gate for the undivided path changes only while clk is low
    always_ff @(negedge clk) begin
        if (rst)
            pass_gate <= 1'b0;
        else
            pass_gate <= run && bypass_mode;
    end

    assign card_clk = div_q | (clk & pass_gate);

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter bit ALLOW_DIV1024 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              bus_idle,
    output logic              card_clk
);

    ctrl_fields_t fields;
    logic         run;
    ratio_exp_t   want_exp;
    ratio_exp_t   act_exp;
    logic         div_q;
    logic         pass_gate;

    sdclk_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_data   (cfg_wdata),
        .ctrl_word (cfg_rdata),
        .fields    (fields)
    );

    sdclk_ratio_decode #(
        .ALLOW_SLOW (ALLOW_DIV1024)
    ) u_dec (
        .fields   (fields),
        .bus_idle (bus_idle),
        .run      (run),
        .want_exp (want_exp)
    );

    sdclk_phase_gen u_gen (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .want_exp  (want_exp),
        .act_exp   (act_exp),
        .div_q     (div_q),
        .pass_gate (pass_gate),
        .card_clk  (card_clk)
    );

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk
    import sdclk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CTRL_W-1:0] cfg_wdata,
    input logic [CTRL_W-1:0] cfg_rdata,
    input logic              bus_idle,
    input logic              div_q,
    input logic              pass_gate,
    input ratio_exp_t        act_exp
);

    // R2
    wr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    // R2
    word_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_rdata));

    // R7
    off_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[CLK_EN_BIT] && !div_q) |=> !div_q);

    // R7
    off_no_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[CLK_EN_BIT] |-> !pass_gate);

    // R8
    idle_parks_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[IDLE_OFF_BIT] && bus_idle && !div_q) |=> !div_q);

    // R9
    ratio_at_low_chk: assert property (@(posedge clk) disable iff (rst)
        (act_exp != $past(act_exp)) |-> !$past(div_q));

endmodule

bind sdclk_divider sdclk_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .bus_idle  (bus_idle),
    .div_q     (div_q),
    .pass_gate (pass_gate),
    .act_exp   (act_exp)
);

// File: tb/sdclk_divider_tb.sv
module sdclk_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SAMP_HI    = CLK_PERIOD / 5;        // inside the high half of clk
    localparam int SAMP_LO    = (CLK_PERIOD * 7) / 10; // inside the low half of clk

    localparam logic [31:0] EN   = 32'h0000_0100;
    localparam logic [31:0] IDLE = 32'h0000_0200;
    localparam logic [31:0] BYP  = 32'h0000_0400;
    localparam logic [31:0] SLOW = 32'h0001_0000;

    typedef struct {
        bit    lvl;
        int    len;
        string req;
    } phase_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [31:0] wd  = '0;
    logic        idle = 1'b0;
    logic [31:0] rd, rd_n;
    logic        cclk, cclk_n;

    int     n_chk = 0;
    int     n_fail = 0;
    int     rise_cnt = 0;
    bit     mon_sync = 1'b0;
    phase_t exp_q[$];

    sdclk_divider #(.ALLOW_DIV1024(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(rd),
        .bus_idle(idle), .card_clk(cclk)
    );

    sdclk_divider #(.ALLOW_DIV1024(1'b0)) u_dut_n (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(rd_n),
        .bus_idle(idle), .card_clk(cclk_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: measures complete phases of card_clk in the low half of clk
    initial begin
        bit     lvl;
        int     len;
        bit     valid;
        phase_t e;
        lvl = 1'b0; len = 0; valid = 1'b0;
        wait (!rst);
        forever begin
            @(posedge clk); #SAMP_LO;
            if (mon_sync) begin
                valid    = 1'b0;
                mon_sync = 1'b0;
            end
            if (cclk !== lvl) begin
                if (valid && exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    // values printed as level*10000 + length
                    chk(e.lvl == lvl && e.len == len, e.req,
                        lvl * 10000 + len, e.lvl * 10000 + e.len);
                end
                if (cclk) rise_cnt++;
                valid = 1'b1;
                lvl   = cclk;
                len   = 1;
            end else begin
                len++;
            end
        end
    end

    task automatic wr(input logic [31:0] v);
        @(posedge clk); #1;
        we = 1'b1; wd = v;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input bit lvl, input int len, input string req);
        phase_t p;
        p.lvl = lvl; p.len = len; p.req = req;
        exp_q.push_back(p);
    endtask

    task automatic push_pairs(input int h, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            push(1'b1, h, req);
            push(1'b0, h, req);
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() > 0) @(posedge clk);
        #1;
    endtask

    task automatic wait_rise();
        int r0;
        r0 = rise_cnt;
        wait (rise_cnt != r0);
    endtask

    task automatic stop_clock();
        wr(32'h0);
        do begin
            @(posedge clk); #SAMP_LO;
        end while (cclk);
        cycles(2);
    endtask

    // counts samples of card_clk that are high over n host cycles
    task automatic count_high(input int n, output int bad);
        bad = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #SAMP_HI;
            if (cclk) bad++;
            #(SAMP_LO - SAMP_HI);
            if (cclk) bad++;
        end
        #1;
    endtask

    task automatic run_steady(input logic [31:0] cfg, input int h, input int n, input string req);
        wr(cfg);
        cycles(3);
        mon_sync = 1'b1;
        push_pairs(h, n, req);
        wr(cfg | EN);
        wait_drain();
        stop_clock();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        int bad;
        int hl;

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(posedge clk); #SAMP_HI;
        chk(rd == 32'h0, "R1 word", rd, 0);
        chk(cclk == 1'b0, "R1 clock", cclk, 0);
        cycles(1);

        // R2: full-word readback, enable clear so no clock runs
        wr(32'h5A5A_00F0);
        chk(rd == 32'h5A5A_00F0, "R2 readback", rd, 32'h5A5A_00F0);
        cycles(4);
        chk(rd == 32'h5A5A_00F0, "R2 hold", rd, 32'h5A5A_00F0);
        wr(32'hFFFF_FC00);
        chk(rd == 32'hFFFF_FC00, "R2 readback", rd, 32'hFFFF_FC00);
        wr(32'h0);

        // R3: empty ratio field gives divide by 2
        run_steady(32'h0, 1, 4, "R3 div2");

        // R3: each one-hot bit
        for (int i = 0; i < 8; i++)
            run_steady(32'h1 << i, 1 << (i + 1), 2, "R3 onehot");

        // R5: highest one-hot wins; bypass ignored beside a one-hot bit
        run_steady(32'h0000_0009, 16, 2, "R5 highest");
        run_steady(BYP | 32'h0000_0004, 8, 2, "R5 bypass ignored");

        // R6: slow bit on both builds
        wr(SLOW | 32'h0000_0001);
        cycles(3);
        mon_sync = 1'b1;
        push_pairs(512, 1, "R6 div1024");
        wr(SLOW | 32'h0000_0001 | EN);
        do begin
            @(posedge clk); #SAMP_LO;
        end while (!cclk_n);
        hl = 0;
        while (cclk_n) begin
            hl++;
            @(posedge clk); #SAMP_LO;
        end
        chk(hl == 256, "R6 capped to 512", hl, 256);
        wait_drain();
        stop_clock();

        // R4: undivided host clock
        wr(BYP);
        cycles(3);
        wr(BYP | EN);
        cycles(4);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #SAMP_HI;
            if (cclk !== 1'b1) bad++;
            #(SAMP_LO - SAMP_HI);
            if (cclk !== 1'b0) bad++;
        end
        chk(bad == 0, "R4 passthrough", bad, 0);
        // R7: host-rate pulses end after the enable is cleared
        wr(BYP);
        count_high(10, bad);
        chk(bad == 0, "R7 passthrough off", bad, 0);
        stop_clock();

        // R7: high phase under way completes, then stays low
        wr(32'h0000_0002);
        cycles(3);
        wr(EN | 32'h0000_0002);
        wait_rise();
        push(1'b1, 4, "R7 last high");
        wr(32'h0000_0002);
        wait_drain();
        count_high(40, bad);
        chk(bad == 0, "R7 held low", bad, 0);
        stop_clock();

        // R8: auto-off with idle bus
        idle = 1'b1;
        wr(IDLE | 32'h0000_0001);
        cycles(3);
        wr(EN | IDLE | 32'h0000_0001);
        count_high(30, bad);
        chk(bad == 0, "R8 idle parked", bad, 0);
        mon_sync = 1'b1;
        push_pairs(2, 2, "R8 resume");
        idle = 1'b0;
        wait_drain();
        idle = 1'b1;
        cycles(6);
        count_high(30, bad);
        chk(bad == 0, "R8 stops on idle", bad, 0);
        mon_sync = 1'b1;
        push_pairs(2, 2, "R8 idle ignored");
        wr(EN | 32'h0000_0001);
        wait_drain();
        stop_clock();
        idle = 1'b0;

        // R9: fast to slow change lands during a high phase
        wr(32'h0000_0001);
        cycles(3);
        wr(EN | 32'h0000_0001);
        cycles(10);
        wait_rise();
        push_pairs(2, 1, "R9 old ratio");
        push_pairs(16, 1, "R9 new ratio");
        wr(EN | 32'h0000_0008);
        wait_drain();
        // R9: slow to fast
        wait_rise();
        push_pairs(16, 1, "R9 old ratio");
        push_pairs(2, 1, "R9 new ratio");
        wr(EN | 32'h0000_0001);
        wait_drain();
        stop_clock();

        // R10: restart waits one full low phase (H = 8)
        wr(32'h0000_0004);
        cycles(3);
        @(posedge clk); #1;
        we = 1'b1; wd = EN | 32'h0000_0004;
        @(posedge clk); #1;
        we = 1'b0;
        #(SAMP_LO - 1);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (cclk) bad++;
            @(posedge clk); #SAMP_LO;
        end
        chk(bad == 0, "R10 first low", bad, 0);
        chk(cclk == 1'b1, "R10 first rise", cclk, 1);
        stop_clock();

        report();
    end

endmodule